// File: doc/BRIEF.md
# Serial audio link frame deserializer

This block sits on the receive side of a bit-serial, time-division-multiplexed audio codec link. It runs on a fast system clock and oversamples three link signals: the bit clock, the frame sync and one or two serial data lines. One data line carries the outbound direction and the other the inbound direction. Every data line is sampled when the bit clock falls.

Each frame is 256 bit times long. It starts with a 16-bit tag slot, followed by twelve slots of 20 bits each. The frame is located from the sync line, which rises one bit time ahead of the first bit. For each finished slot, the block pulses a per-direction strobe for one system clock. With that strobe it presents the slot number, the right-justified slot value and a 16-bit audio word. Downstream logic, such as a register decoder or a sample FIFO, picks the slots it needs off this stream.

Each data direction can be left out at build time through a parameter. At least one direction must remain enabled. The system clock must run at least four times faster than the bit clock.

Top module: `ac_link_deserializer`

## Requirements
- R1: After reset all outputs are zero and the block is unframed, so no strobe appears until a frame start is detected, even if the bit clock keeps toggling.
- R2: Data and sync are taken from the link lines as they stand when the bit clock falls; values present only while it is high have no effect.
- R3: A frame begins at the bit that follows the first falling-edge sample with sync at 1 directly after one with sync at 0; `frame_start` pulses for one clock at that bit.
- R4: The frame is split into slot 0 of 16 bits and slots 1 to 12 of 20 bits each, so a slot ends after frame bits 15, 35, 55 and so on up to 255. `slot_idx` runs 0 to 12 in order within a frame.
- R5: Slot bits are shifted in MSB first, and the slot value is right-justified. For slot 0, bits 19 to 16 of the value are zero.
- R6: Bits after the 256th bit of a frame are ignored and give no strobe until the next frame start.
- R7: A frame start found in the middle of a frame abandons the partial slot and restarts at slot 0.
- R8: `slot_stb` bit 0 marks the outbound (tx) direction and bit 1 the inbound (rx) direction. When both directions are enabled, the two strobes fire in the same cycle. A disabled direction never strobes.
- R9: With each strobe, the audio word is bits 19 to 4 of the slot value for slots 1 to 12, and zero for slot 0.
- R10: Each strobe lasts exactly one clock. `slot_idx` and the slot values hold their contents between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_clk | input | 1 | Link bit clock |
| link_sync | input | 1 | Link frame sync |
| line_tx | input | 1 | Outbound serial data line |
| line_rx | input | 1 | Inbound serial data line |
| frame_start | output | 1 | One-clock pulse at bit 0 of each frame |
| slot_stb | output | 2 | Slot done strobes; bit 0 tx, bit 1 rx |
| slot_idx | output | 4 | Number of the slot just finished |
| tx_slot_value | output | 20 | Outbound slot value, right-justified |
| rx_slot_value | output | 20 | Inbound slot value, right-justified |
| tx_audio | output | 16 | Outbound audio word |
| rx_audio | output | 16 | Inbound audio word |

## Verification
The assertions watch the properties that hold on every cycle. These are the one-clock width of the strobes and of `frame_start`, the strict 0-to-12 slot order after each frame start, the zero upper nibble of slot 0, the link between the audio word and the slot value, a silent disabled direction, and a slot index that holds between strobes. Other behaviour only shows against known serial input, so the bench scenarios cover it. That includes whether the right bits land in each slot, which clock edge samples them, the exact bit where a frame begins, the silence after bit 256, a resync in the middle of a frame and frames sent back to back.

// File: rtl/ac_link_pkg.sv
// Shared definitions for the serial audio link deserializer.
// Assumes two data directions: lane 0 outbound, lane 1 inbound.
package ac_link_pkg;

    localparam int LANE_TX   = 0;
    localparam int LANE_RX   = 1;
    localparam int NUM_LANES = 2;

    // One oversampled view of the link, valid in the cycle where fall is set.
    typedef struct packed {
        logic                 fall;
        logic                 sync;
        logic [NUM_LANES-1:0] data;
    } link_sample_t;

endpackage

// File: rtl/ac_link_sampler.sv
// Registers the link lines into the system clock domain and flags the
// falling edge of the bit clock. Assumes the link lines are already
// synchronous to clk, or slow enough that one register stage is enough.
// Data and sync are taken from the stage that first shows the bit clock low.
module ac_link_sampler
    import ac_link_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_clk,
    input  logic                 link_sync,
    input  logic [NUM_LANES-1:0] link_data,
    output link_sample_t         smp
);

    logic                 clk_q;
    logic                 clk_qq;
    logic                 sync_q;
    logic [NUM_LANES-1:0] data_q;

    // Capture stage: the line values and a delayed copy of the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            clk_qq <= 1'b0;
            sync_q <= 1'b0;
            data_q <= '0;
        end else begin
            clk_q  <= link_clk;
            clk_qq <= clk_q;
            sync_q <= link_sync;
            data_q <= link_data;
        end
    end

    // Present the sample with a one-cycle falling-edge marker.
    always_comb begin
        smp.fall = clk_qq & ~clk_q;
        smp.sync = sync_q;
        smp.data = data_q;
    end

endmodule

// File: rtl/ac_link_framer.sv
// Tracks frame position. It finds the frame start from the sync history of
// the last two falling-edge samples, then counts slots and the bits within
// each slot. After the final slot it stays idle until the next start.
// Its outputs are combinational from the current sample, so the lanes
// register the result in the same cycle as the counters.
module ac_link_framer #(
    parameter  int TAG_BITS       = 16,
    parameter  int DATA_BITS      = 20,
    parameter  int NUM_DATA_SLOTS = 12,
    localparam int SLOT_W         = $clog2(NUM_DATA_SLOTS + 1),
    localparam int MAX_BITS       = (DATA_BITS > TAG_BITS) ? DATA_BITS : TAG_BITS,
    localparam int BIT_W          = $clog2(MAX_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              sync,
    output logic              start,
    output logic              take,
    output logic              last,
    output logic [SLOT_W-1:0] cur_slot
);

    localparam logic [BIT_W-1:0]  TAG_LAST   = BIT_W'(TAG_BITS - 1);
    localparam logic [BIT_W-1:0]  DATA_LAST  = BIT_W'(DATA_BITS - 1);
    localparam logic [SLOT_W-1:0] FINAL_SLOT = SLOT_W'(NUM_DATA_SLOTS);

    logic              sync_p1;
    logic              sync_p2;
    logic              in_frame;
    logic [SLOT_W-1:0] slot_no;
    logic [BIT_W-1:0]  bit_no;
    logic [BIT_W-1:0]  cur_bit;
    logic [BIT_W-1:0]  slot_end;

    // Decode the start pattern, and the position of the bit being taken now.
    always_comb begin
        start    = fall & sync_p1 & ~sync_p2;
        take     = fall & (start | in_frame);
        cur_slot = start ? '0 : slot_no;
        cur_bit  = start ? '0 : bit_no;
        slot_end = (cur_slot == '0) ? TAG_LAST : DATA_LAST;
        last     = take & (cur_bit == slot_end);
    end

    // Advance the sync history and the slot and bit counters on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_p1  <= 1'b1;
            sync_p2  <= 1'b1;
            in_frame <= 1'b0;
            slot_no  <= '0;
            bit_no   <= '0;
        end else begin
            if (fall) begin
                sync_p2 <= sync_p1;
                sync_p1 <= sync;
            end
            if (take) begin
                if (last) begin
                    bit_no <= '0;
                    if (cur_slot == FINAL_SLOT) begin
                        in_frame <= 1'b0;
                        slot_no  <= '0;
                    end else begin
                        in_frame <= 1'b1;
                        slot_no  <= cur_slot + 1'b1;
                    end
                end else begin
                    in_frame <= 1'b1;
                    slot_no  <= cur_slot;
                    bit_no   <= cur_bit + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ac_link_lane.sv
// Per-direction slot assembler. It shifts one bit in, MSB first, on each
// accepted edge. At a slot end it registers the right-justified value and
// its audio word, and strobes for one cycle. The shifter is cleared at a
// slot end and at a frame start, so a short tag slot reads zero in its
// upper bits.
module ac_link_lane #(
    parameter int DATA_BITS  = 20,
    parameter int AUDIO_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  last,
    input  logic                  restart,
    input  logic                  bit_in,
    input  logic                  slot_is_tag,
    output logic                  stb,
    output logic [DATA_BITS-1:0]  value,
    output logic [AUDIO_BITS-1:0] audio
);

    logic [DATA_BITS-2:0] sh;
    logic [DATA_BITS-1:0] full;

    // Value the slot would have if this bit were its last one.
    always_comb begin
        full = {(restart ? '0 : sh), bit_in};
    end

    // Shift, and hand off on the slot's last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            stb   <= 1'b0;
            value <= '0;
            audio <= '0;
        end else begin
            stb <= take & last;
            if (take) begin
                sh <= last ? '0 : full[DATA_BITS-2:0];
            end
            if (take && last) begin
                value <= full;
                audio <= slot_is_tag ? '0 : full[DATA_BITS-1 -: AUDIO_BITS];
            end
        end
    end

endmodule

// File: rtl/ac_link_deserializer.sv
// Top of the serial audio link deserializer: sampler, then framer, then one
// slot assembler per enabled direction. Assumes clk runs at least 4x the
// link bit clock and that at least one direction is enabled.
module ac_link_deserializer
    import ac_link_pkg::*;
#(
    parameter  bit OUT_LANE_EN    = 1'b1,
    parameter  bit IN_LANE_EN     = 1'b1,
    parameter  int TAG_BITS       = 16,
    parameter  int DATA_BITS      = 20,
    parameter  int NUM_DATA_SLOTS = 12,
    parameter  int AUDIO_BITS     = 16,
    localparam int SLOT_W         = $clog2(NUM_DATA_SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  link_clk,
    input  logic                  link_sync,
    input  logic                  line_tx,
    input  logic                  line_rx,
    output logic                  frame_start,
    output logic [NUM_LANES-1:0]  slot_stb,
    output logic [SLOT_W-1:0]     slot_idx,
    output logic [DATA_BITS-1:0]  tx_slot_value,
    output logic [DATA_BITS-1:0]  rx_slot_value,
    output logic [AUDIO_BITS-1:0] tx_audio,
    output logic [AUDIO_BITS-1:0] rx_audio
);

    localparam logic [NUM_LANES-1:0] LANE_EN = {IN_LANE_EN, OUT_LANE_EN};

    link_sample_t         smp;
    logic [NUM_LANES-1:0] link_data;
    logic                 start;
    logic                 take;
    logic                 last;
    logic [SLOT_W-1:0]    cur_slot;

    logic [NUM_LANES-1:0]  lane_stb;
    logic [DATA_BITS-1:0]  lane_val [NUM_LANES];
    logic [AUDIO_BITS-1:0] lane_aud [NUM_LANES];

    assign link_data[LANE_TX] = line_tx;
    assign link_data[LANE_RX] = line_rx;

    ac_link_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_clk  (link_clk),
        .link_sync (link_sync),
        .link_data (link_data),
        .smp       (smp)
    );

    ac_link_framer #(
        .TAG_BITS       (TAG_BITS),
        .DATA_BITS      (DATA_BITS),
        .NUM_DATA_SLOTS (NUM_DATA_SLOTS)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (smp.fall),
        .sync     (smp.sync),
        .start    (start),
        .take     (take),
        .last     (last),
        .cur_slot (cur_slot)
    );

    // One assembler per enabled direction; a disabled one drives zeros.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (LANE_EN[g]) begin : g_on
            ac_link_lane #(
                .DATA_BITS  (DATA_BITS),
                .AUDIO_BITS (AUDIO_BITS)
            ) u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .take        (take),
                .last        (last),
                .restart     (start),
                .bit_in      (smp.data[g]),
                .slot_is_tag (cur_slot == '0),
                .stb         (lane_stb[g]),
                .value       (lane_val[g]),
                .audio       (lane_aud[g])
            );
        end else begin : g_off
            assign lane_stb[g] = 1'b0;
            assign lane_val[g] = '0;
            assign lane_aud[g] = '0;
        end
    end

    // Frame marker and the shared slot number, registered alongside the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            slot_idx    <= '0;
        end else begin
            frame_start <= start;
            if (last) begin
                slot_idx <= cur_slot;
            end
        end
    end

    assign slot_stb      = lane_stb;
    assign tx_slot_value = lane_val[LANE_TX];
    assign rx_slot_value = lane_val[LANE_RX];
    assign tx_audio      = lane_aud[LANE_TX];
    assign rx_audio      = lane_aud[LANE_RX];

endmodule

// File: rtl/ac_link_deserializer_chk.sv
// Property checker for ac_link_deserializer, attached by bind. It watches
// only the top ports, plus a small record of the last slot seen.
module ac_link_deserializer_chk #(
    parameter  bit OUT_LANE_EN    = 1'b1,
    parameter  bit IN_LANE_EN     = 1'b1,
    parameter  int DATA_BITS      = 20,
    parameter  int NUM_DATA_SLOTS = 12,
    parameter  int AUDIO_BITS     = 16,
    localparam int SLOT_W         = $clog2(NUM_DATA_SLOTS + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_start,
    input logic [1:0]            slot_stb,
    input logic [SLOT_W-1:0]     slot_idx,
    input logic [DATA_BITS-1:0]  tx_slot_value,
    input logic [DATA_BITS-1:0]  rx_slot_value,
    input logic [AUDIO_BITS-1:0] tx_audio,
    input logic [AUDIO_BITS-1:0] rx_audio
);

    localparam logic [SLOT_W-1:0] NONE = '1;

    logic              any_stb;
    logic [SLOT_W-1:0] prev_idx;

    assign any_stb = |slot_stb;

    // Remember the last slot number; a frame start clears the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idx <= NONE;
        end else if (frame_start) begin
            prev_idx <= NONE;
        end else if (any_stb) begin
            prev_idx <= slot_idx;
        end
    end

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r3_start_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !any_stb);

    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> slot_idx <= SLOT_W'(NUM_DATA_SLOTS));

    a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && slot_idx != '0) |-> prev_idx == slot_idx - 1'b1);

    a_r4_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && slot_idx == '0) |-> prev_idx == NONE);

    a_r5_tag_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb[0] && slot_idx == '0) |-> tx_slot_value[DATA_BITS-1:16] == '0);

    a_r9_tx_audio: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb[0] && slot_idx != '0) |->
            tx_audio == tx_slot_value[DATA_BITS-1 -: AUDIO_BITS]);

    a_r9_rx_audio: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb[1] && slot_idx != '0) |->
            rx_audio == rx_slot_value[DATA_BITS-1 -: AUDIO_BITS]);

    a_r9_tag_audio_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && slot_idx == '0) |-> (tx_audio == '0 && rx_audio == '0));

    a_r10_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb[0] |=> !slot_stb[0]);

    a_r10_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb[1] |=> !slot_stb[1]);

    a_r10_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_stb |-> $stable(slot_idx));

    if (OUT_LANE_EN && IN_LANE_EN) begin : g_both
        a_r8_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
            slot_stb[0] == slot_stb[1]);
    end
    if (!OUT_LANE_EN) begin : g_no_tx
        a_r8_tx_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_stb[0]);
    end
    if (!IN_LANE_EN) begin : g_no_rx
        a_r8_rx_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_stb[1]);
    end

endmodule

bind ac_link_deserializer ac_link_deserializer_chk #(
    .OUT_LANE_EN    (OUT_LANE_EN),
    .IN_LANE_EN     (IN_LANE_EN),
    .DATA_BITS      (DATA_BITS),
    .NUM_DATA_SLOTS (NUM_DATA_SLOTS),
    .AUDIO_BITS     (AUDIO_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .slot_stb      (slot_stb),
    .slot_idx      (slot_idx),
    .tx_slot_value (tx_slot_value),
    .rx_slot_value (rx_slot_value),
    .tx_audio      (tx_audio),
    .rx_audio      (rx_audio)
);

// File: tb/ac_link_deserializer_test.sv
`timescale 1ns/1ps
module ac_link_deserializer_test;

    // Frame vectors: {tx tag, tx base, rx tag, rx base}.
    // Slot k > 0 carries base ^ (k * 0x11111).
    localparam logic [71:0] VECS [4] = '{
        72'h0000_00000_0000_00000,
        72'hFFFF_FFFFF_FFFF_FFFFF,
        72'hA5C3_5A5A5_3C5A_A5A5A,
        72'h8001_80001_0001_00010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lclk = 1'b0;
    logic fsync = 1'b0;
    logic ltx = 1'b0;
    logic lrx = 1'b0;

    logic        fs, ib_fs;
    logic [1:0]  stb, ib_stb;
    logic [3:0]  idx, ib_idx;
    logic [19:0] txv, rxv, ib_txv, ib_rxv;
    logic [15:0] txa, rxa, ib_txa, ib_rxa;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int n_tx, n_rx, n_fs, n_ibtx, n_ibrx;
    logic [3:0]  ev_tx_idx [64];
    logic [19:0] ev_tx_val [64];
    logic [15:0] ev_tx_aud [64];
    int          ev_tx_t   [64];
    logic [3:0]  ev_rx_idx [64];
    logic [19:0] ev_rx_val [64];
    logic [15:0] ev_rx_aud [64];
    int          ev_rx_t   [64];
    logic [19:0] ev_ib_val [64];

    ac_link_deserializer uut (
        .clk(clk), .rst_n(rst_n), .link_clk(lclk), .link_sync(fsync),
        .line_tx(ltx), .line_rx(lrx), .frame_start(fs), .slot_stb(stb),
        .slot_idx(idx), .tx_slot_value(txv), .rx_slot_value(rxv),
        .tx_audio(txa), .rx_audio(rxa)
    );

    ac_link_deserializer #(.OUT_LANE_EN(1'b0)) uut_ib (
        .clk(clk), .rst_n(rst_n), .link_clk(lclk), .link_sync(fsync),
        .line_tx(ltx), .line_rx(lrx), .frame_start(ib_fs), .slot_stb(ib_stb),
        .slot_idx(ib_idx), .tx_slot_value(ib_txv), .rx_slot_value(ib_rxv),
        .tx_audio(ib_txa), .rx_audio(ib_rxa)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record the output events away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fs) n_fs++;
            if (stb[0]) begin
                if (n_tx < 64) begin
                    ev_tx_idx[n_tx] = idx; ev_tx_val[n_tx] = txv;
                    ev_tx_aud[n_tx] = txa; ev_tx_t[n_tx] = cyc;
                end
                n_tx++;
            end
            if (stb[1]) begin
                if (n_rx < 64) begin
                    ev_rx_idx[n_rx] = idx; ev_rx_val[n_rx] = rxv;
                    ev_rx_aud[n_rx] = rxa; ev_rx_t[n_rx] = cyc;
                end
                n_rx++;
            end
            if (ib_stb[0]) n_ibtx++;
            if (ib_stb[1]) begin
                if (n_ibrx < 64) ev_ib_val[n_ibrx] = ib_rxv;
                n_ibrx++;
            end
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_ev();
        n_tx = 0; n_rx = 0; n_fs = 0; n_ibtx = 0; n_ibrx = 0;
    endtask

    function automatic logic [19:0] slot_val(input logic [15:0] t,
                                             input logic [19:0] b, input int k);
        if (k == 0) return {4'h0, t};
        return b ^ 20'(k * 32'h11111);
    endfunction

    function automatic logic frame_bit(input logic [15:0] t,
                                       input logic [19:0] b, input int p);
        logic [19:0] v;
        if (p < 16) return t[15 - p];
        v = slot_val(t, b, (p - 16) / 20 + 1);
        return v[19 - ((p - 16) % 20)];
    endfunction

    // One bit time: wrong data while the bit clock is high, the real bit
    // before and through the falling edge (R2).
    task automatic send_bit(input logic s, input logic o, input logic i);
        @(negedge clk);
        lclk = 1'b1; fsync = s; ltx = ~o; lrx = ~i;
        repeat (2) @(negedge clk);
        ltx = o; lrx = i;
        repeat (2) @(negedge clk);
        lclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input bit pre, input int n, input logic [71:0] v);
        if (pre) begin
            send_bit(1'b0, 1'b0, 1'b0);
            send_bit(1'b1, 1'b0, 1'b0);
        end
        for (int p = 0; p < n; p++)
            send_bit(p < 15, frame_bit(v[71:56], v[55:36], p),
                             frame_bit(v[35:20], v[19:0], p));
    endtask

    task automatic trail_bits(input int n);
        for (int p = 0; p < n; p++) send_bit(1'b0, p[0], ~p[0]);
        repeat (10) @(negedge clk);
    endtask

    task automatic check_frame(input logic [71:0] v, input int otx, input int orx);
        for (int k = 0; k < 13; k++) begin
            logic [19:0] et, er;
            et = slot_val(v[71:56], v[55:36], k);
            er = slot_val(v[35:20], v[19:0], k);
            chk(ev_tx_idx[otx+k] == 4'(k) && ev_tx_val[otx+k] == et,
                "R4 R5 tx slot", {ev_tx_idx[otx+k], ev_tx_val[otx+k]}, {4'(k), et});
            chk(ev_rx_idx[orx+k] == 4'(k) && ev_rx_val[orx+k] == er,
                "R4 R5 rx slot", {ev_rx_idx[orx+k], ev_rx_val[orx+k]}, {4'(k), er});
            chk(ev_tx_aud[otx+k] == ((k == 0) ? 16'h0 : et[19:4]),
                "R9 tx audio", ev_tx_aud[otx+k], (k == 0) ? 16'h0 : et[19:4]);
            chk(ev_rx_aud[orx+k] == ((k == 0) ? 16'h0 : er[19:4]),
                "R9 rx audio", ev_rx_aud[orx+k], (k == 0) ? 16'h0 : er[19:4]);
            chk(ev_tx_t[otx+k] == ev_rx_t[orx+k], "R8 same cycle",
                ev_tx_t[otx+k], ev_rx_t[orx+k]);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        clear_ev();
        repeat (4) @(negedge clk);
        chk(fs == 0 && stb == 0 && idx == 0 && txv == 0 && rxv == 0 &&
            txa == 0 && rxa == 0, "R1 reset outputs",
            {fs, stb, idx, txv, rxv}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: the bit clock toggles without a start pattern: no strobes.
        for (int p = 0; p < 30; p++) send_bit(1'b0, p[0], p[1]);
        repeat (10) @(negedge clk);
        chk(n_tx == 0 && n_rx == 0 && n_fs == 0, "R1 unframed silent",
            n_tx + n_rx + n_fs, 0);

        // Table of frames, with bits after the frame that must be ignored.
        for (int v = 0; v < 4; v++) begin
            clear_ev();
            send_frame(1'b1, 256, VECS[v]);
            trail_bits(8);
            chk(n_fs == 1, "R3 one frame start", n_fs, 1);
            chk(n_tx == 13 && n_rx == 13, "R6 no strobes after bit 256",
                {n_tx, n_rx}, {32'd13, 32'd13});
            check_frame(VECS[v], 0, 0);
            chk(n_ibtx == 0, "R8 disabled tx lane silent", n_ibtx, 0);
            chk(n_ibrx == 13, "R8 rx-only lane count", n_ibrx, 13);
            for (int k = 0; k < 13; k++) begin
                logic [19:0] er;
                er = slot_val(VECS[v][35:20], VECS[v][19:0], k);
                chk(ev_ib_val[k] == er, "R8 rx-only lane value", ev_ib_val[k], er);
            end
        end

        // R7: resync in slot 2 of frame A, then a full frame B.
        clear_ev();
        send_frame(1'b1, 38, VECS[2]);
        send_bit(1'b1, frame_bit(VECS[2][71:56], VECS[2][55:36], 38),
                       frame_bit(VECS[2][35:20], VECS[2][19:0], 38));
        send_frame(1'b0, 256, VECS[3]);
        trail_bits(4);
        chk(n_fs == 2, "R7 second start", n_fs, 2);
        chk(n_tx == 15 && n_rx == 15, "R7 partial slot dropped",
            {n_tx, n_rx}, {32'd15, 32'd15});
        chk(ev_tx_idx[1] == 4'd1 && ev_tx_val[1] == slot_val(VECS[2][71:56], VECS[2][55:36], 1),
            "R7 slot 1 before resync", ev_tx_val[1],
            slot_val(VECS[2][71:56], VECS[2][55:36], 1));
        check_frame(VECS[3], 2, 2);

        // R3: back to back, sync rises during bit 255 of the first frame.
        clear_ev();
        send_frame(1'b1, 255, VECS[1]);
        send_bit(1'b1, frame_bit(VECS[1][71:56], VECS[1][55:36], 255),
                       frame_bit(VECS[1][35:20], VECS[1][19:0], 255));
        send_frame(1'b0, 256, VECS[2]);
        trail_bits(4);
        chk(n_fs == 2 && n_tx == 26, "R3 back-to-back frames",
            {n_fs, n_tx}, {32'd2, 32'd26});
        check_frame(VECS[1], 0, 0);
        check_frame(VECS[2], 13, 13);

        // R1: reset in mid-frame leaves the block unframed.
        clear_ev();
        send_frame(1'b1, 100, VECS[3]);
        chk(n_tx == 5, "R4 slots done by bit 100", n_tx, 5);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(stb == 0 && idx == 0 && txv == 0, "R1 reset clears outputs",
            {stb, idx, txv}, 64'h0);
        rst_n = 1'b1;
        trail_bits(40);
        chk(n_tx == 5 && n_fs == 1, "R1 no strobes after reset",
            {n_tx, n_fs}, {32'd5, 32'd1});
        send_frame(1'b1, 256, VECS[0]);
        trail_bits(2);
        chk(n_tx == 18, "R3 frame found after reset", n_tx, 18);
        check_frame(VECS[0], 5, 5);

        summary();
        $finish;
    end

endmodule